// File: doc/BRIEF.md
# Opcode-Stream SPI Controller

This block turns a stream of command bytes into activity on a serial peripheral bus. A host pushes bytes through an 8-bit valid/ready input. The block decodes each opcode, collects the argument bytes that follow it, and then does one of the following:

- sets the serial clock rate;
- bypasses a front prescaler;
- cuts an internal data loopback;
- drives eight general-purpose pins with a value and a direction;
- shifts data bytes out;
- clocks bytes in and hands them to the consumer on an 8-bit valid/ready output.

Commands are packed back to back. A typical transaction is: pull chip select low, write an opcode and an address, read the response, release chip select. The controller carries out the commands strictly in the order they arrive.

Pin 0 of the pin group carries the serial clock and pin 1 carries the outgoing data. Both are produced by the shift engine. Pins 2 to 7 follow the last written value. Pin 3 is the active-low chip select. The incoming data line is a separate input.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, pins_out is 0x08 (chip select high, clock and data low), pins_oe is 0x0B, err_flag is 0, out_valid is 0 and in_ready is 1.
- R2: Byte 0x80 followed by a value byte V and a direction byte D sets pins_oe to D and pins_out[7:2] to V[7:2]; pins_out[1:0] stay driven by the shift engine.
- R3: Byte 0x86 followed by L then H sets divisor N = {H,L}. The clock high phase and low phase each last (N+1)*M system clocks, where M is 5 until the prescaler is bypassed and 1 after that. N is 0 after reset.
- R4: Byte 0x8A bypasses the prescaler (M becomes 1). It takes no argument bytes.
- R5: Byte 0x11 followed by L, H and then {H,L}+1 data bytes shifts each data byte out MSB first. Data changes only while the clock is low and is stable on every rising edge.
- R6: Byte 0x20 followed by L and H clocks in {H,L}+1 bytes MSB first, sampling on rising clock edges, and pushes each byte to the output stream. The outgoing data line stays low during the read.
- R7: After reset, received bits come from the outgoing data line (loopback), so reads return 0x00. Byte 0x85 (no arguments) switches reception to spi_miso.
- R8: Commands packed in one stream run in arrival order. A chip-select release placed after a read takes effect only after the read bytes have been delivered.
- R9: Any other opcode byte sets err_flag, which stays set until reset. The byte is dropped, and the next byte is decoded as an opcode.
- R10: in_ready is 0 while a byte is shifting and while a read byte waits at the output. out_valid and out_data hold until out_ready, and the clock does not advance in the meantime.
- R11: The serial clock is low whenever no byte is shifting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Command stream byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Controller accepts a byte this cycle |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | Consumer takes out_data |
| pins_out | output | 8 | Pin levels: bit 0 clock, bit 1 outgoing data, bit 3 chip select |
| pins_oe | output | 8 | Pin directions, 1 = output |
| spi_miso | input | 1 | Incoming serial data |
| err_flag | output | 1 | Sticky bad-opcode flag |

## Verification
A parser that loses its place in the stream treats a data byte as an opcode. This shows up within one command either as a raised err_flag or as wrong pin levels once the following pin command runs. A wrong divisor or prescaler state changes the measured clock high time on the very next byte shifted. A shift counter that is off, or a loopback select that is wrong, corrupts the byte logged on the data line or the byte returned at the output within that same transfer. Broken back-pressure shows as clock edges, or a changed output byte, while out_ready is held low.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OPC_PINS     = 8'h80;
   localparam logic [BYTE_W-1:0] OPC_LOOP_OFF = 8'h85;
   localparam logic [BYTE_W-1:0] OPC_DIV      = 8'h86;
   localparam logic [BYTE_W-1:0] OPC_FAST     = 8'h8A;
   localparam logic [BYTE_W-1:0] OPC_WRITE    = 8'h11;
   localparam logic [BYTE_W-1:0] OPC_READ     = 8'h20;

   localparam int PIN_SCK  = 0;
   localparam int PIN_MOSI = 1;

   typedef enum logic [2:0] {
      ST_OP, ST_ARG1, ST_ARG2, ST_WDATA, ST_WSHIFT, ST_RSHIFT, ST_PUSH
   } state_t;

   typedef enum logic [1:0] {
      K_PINS, K_DIV, K_WRITE, K_READ
   } kind_t;
endpackage

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
   parameter int DIV_W    = 16,
   parameter int PRESCALE = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             fast,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int PS_W  = $clog2(PRESCALE + 1);
   localparam int LIM_W = DIV_W + PS_W + 1;
   localparam logic [LIM_W-1:0] ONE = LIM_W'(1);
   localparam logic [LIM_W-1:0] PRE = LIM_W'(PRESCALE);

   logic [LIM_W-1:0] limit;
   logic [LIM_W-1:0] cnt;

   always_comb limit = (LIM_W'(div) + ONE) * (fast ? ONE : PRE) - ONE;

   assign tick = en && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!en || tick) cnt <= '0;
      else                  cnt <= cnt + ONE;
   end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
   import spi_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [BYTE_W-1:0] tx,
   input  logic              tick,
   input  logic              miso,
   output logic              busy,
   output logic              sck,
   output logic              mosi,
   output logic [BYTE_W-1:0] rx,
   output logic              done
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] sh;
   logic [CNT_W-1:0]  nbit;

   assign mosi = busy & sh[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         nbit <= '0;
         busy <= 1'b0;
         sck  <= 1'b0;
         rx   <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            sh   <= tx;
            nbit <= '0;
            busy <= 1'b1;
            sck  <= 1'b0;
         end else if (busy && tick) begin
            if (!sck) begin
               sck <= 1'b1;
               rx  <= {rx[BYTE_W-2:0], miso};
            end else begin
               sck  <= 1'b0;
               sh   <= {sh[BYTE_W-2:0], 1'b0};
               nbit <= nbit + CNT_W'(1);
               if (nbit == LAST) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int                DIV_W        = 16,
   parameter int                LEN_W        = 16,
   parameter int                PRESCALE     = 5,
   parameter logic [DIV_W-1:0]  DIV_RST      = '0,
   parameter logic [BYTE_W-1:0] PIN_RST_VAL  = 8'h08,
   parameter logic [BYTE_W-1:0] PIN_RST_DIR  = 8'h0B,
   parameter bit                LOOPBACK_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] pins_out,
   output logic [BYTE_W-1:0] pins_oe,
   input  logic              spi_miso,
   output logic              err_flag
);
   localparam int ARG_W = 2 * BYTE_W;

   if (DIV_W < 1 || DIV_W > ARG_W) begin : g_bad_div
      $error("DIV_W must lie in 1..16");
   end
   if (LEN_W < 1 || LEN_W > ARG_W) begin : g_bad_len
      $error("LEN_W must lie in 1..16");
   end
   if (PRESCALE < 1) begin : g_bad_pre
      $error("PRESCALE must be at least 1");
   end

   state_t            st;
   kind_t             kind;
   logic [BYTE_W-1:0] arg_lo;
   logic [LEN_W-1:0]  remain;
   logic [DIV_W-1:0]  div_q;
   logic              fast_q;
   logic              loop_q;
   logic [BYTE_W-1:2] pval_q;
   logic [BYTE_W-1:0] pdir_q;
   logic              err_q;
   logic [BYTE_W-1:0] odata_q;
   logic              ovalid_q;

   logic              take;
   logic [ARG_W-1:0]  arg16;
   logic              go;
   logic [BYTE_W-1:0] go_byte;
   logic              tick;
   logic              busy;
   logic              sck_w;
   logic              mosi_w;
   logic              miso_w;
   logic [BYTE_W-1:0] rx_w;
   logic              done_w;

   assign take  = in_valid & in_ready;
   assign arg16 = {in_data, arg_lo};

   always_comb begin
      in_ready = (st == ST_OP) || (st == ST_ARG1) ||
                 (st == ST_ARG2) || (st == ST_WDATA);
   end

   always_comb begin
      go      = 1'b0;
      go_byte = '0;
      if (take && st == ST_WDATA) begin
         go      = 1'b1;
         go_byte = in_data;
      end else if (take && st == ST_ARG2 && kind == K_READ) begin
         go = 1'b1;
      end else if (st == ST_PUSH && out_ready && remain != '0) begin
         go = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_OP;
         kind     <= K_PINS;
         arg_lo   <= '0;
         remain   <= '0;
         div_q    <= DIV_RST;
         fast_q   <= 1'b0;
         loop_q   <= LOOPBACK_RST;
         pval_q   <= PIN_RST_VAL[BYTE_W-1:2];
         pdir_q   <= PIN_RST_DIR;
         err_q    <= 1'b0;
         odata_q  <= '0;
         ovalid_q <= 1'b0;
      end else begin
         case (st)
            ST_OP: if (take) begin
               case (in_data)
                  OPC_PINS:     begin kind <= K_PINS;  st <= ST_ARG1; end
                  OPC_DIV:      begin kind <= K_DIV;   st <= ST_ARG1; end
                  OPC_WRITE:    begin kind <= K_WRITE; st <= ST_ARG1; end
                  OPC_READ:     begin kind <= K_READ;  st <= ST_ARG1; end
                  OPC_FAST:     fast_q <= 1'b1;
                  OPC_LOOP_OFF: loop_q <= 1'b0;
                  default:      err_q  <= 1'b1;
               endcase
            end
            ST_ARG1: if (take) begin
               arg_lo <= in_data;
               st     <= ST_ARG2;
            end
            ST_ARG2: if (take) begin
               case (kind)
                  K_PINS: begin
                     pval_q <= arg_lo[BYTE_W-1:2];
                     pdir_q <= in_data;
                     st     <= ST_OP;
                  end
                  K_DIV: begin
                     div_q <= arg16[DIV_W-1:0];
                     st    <= ST_OP;
                  end
                  K_WRITE: begin
                     remain <= arg16[LEN_W-1:0];
                     st     <= ST_WDATA;
                  end
                  default: begin
                     remain <= arg16[LEN_W-1:0];
                     st     <= ST_RSHIFT;
                  end
               endcase
            end
            ST_WDATA: if (take) st <= ST_WSHIFT;
            ST_WSHIFT: if (done_w) begin
               if (remain == '0) st <= ST_OP;
               else begin
                  remain <= remain - LEN_W'(1);
                  st     <= ST_WDATA;
               end
            end
            ST_RSHIFT: if (done_w) begin
               odata_q  <= rx_w;
               ovalid_q <= 1'b1;
               st       <= ST_PUSH;
            end
            ST_PUSH: if (out_ready) begin
               ovalid_q <= 1'b0;
               if (remain == '0) st <= ST_OP;
               else begin
                  remain <= remain - LEN_W'(1);
                  st     <= ST_RSHIFT;
               end
            end
            default: st <= ST_OP;
         endcase
      end
   end

   assign miso_w = loop_q ? mosi_w : spi_miso;

   spi_cmd_clkdiv #(
      .DIV_W    (DIV_W),
      .PRESCALE (PRESCALE)
   ) i_clkdiv (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (busy),
      .fast  (fast_q),
      .div   (div_q),
      .tick  (tick)
   );

   spi_cmd_shifter i_shifter (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .tx    (go_byte),
      .tick  (tick),
      .miso  (miso_w),
      .busy  (busy),
      .sck   (sck_w),
      .mosi  (mosi_w),
      .rx    (rx_w),
      .done  (done_w)
   );

   for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_pin
      if (gi == PIN_SCK) begin : g_sck
         assign pins_out[gi] = sck_w;
      end else if (gi == PIN_MOSI) begin : g_mosi
         assign pins_out[gi] = mosi_w;
      end else begin : g_gpio
         assign pins_out[gi] = pval_q[gi];
      end
   end

   assign pins_oe   = pdir_q;
   assign out_data  = odata_q;
   assign out_valid = ovalid_q;
   assign err_flag  = err_q;
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       in_ready,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic [7:0] pins_out,
   input logic       err_flag
);
   AST_NO_CLOCK_WHILE_ACCEPTING: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !pins_out[0]);                                       // R11
   AST_HIGH_CLOCK_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      pins_out[0] |-> !in_ready);                                       // R10
   AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R10
   AST_CLOCK_FROZEN_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> $stable(pins_out[0]));              // R10
   AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);                                           // R9
   AST_DATA_LOW_ON_PENDING_READ: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !pins_out[1]);                                      // R6
endmodule

bind spi_cmd_engine spi_cmd_checker i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .pins_out  (pins_out),
   .err_flag  (err_flag)
);

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] in_data;
   logic       in_valid;
   logic       in_ready;
   logic [7:0] out_data;
   logic       out_valid;
   logic       out_ready;
   logic [7:0] pins_out;
   logic [7:0] pins_oe;
   logic       spi_miso;
   logic       err_flag;

   always #2 clk = ~clk;

   spi_cmd_engine i_spi_cmd_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .out_data  (out_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .pins_out  (pins_out),
      .pins_oe   (pins_oe),
      .spi_miso  (spi_miso),
      .err_flag  (err_flag)
   );

   int n_chk  = 0;
   int n_fail = 0;

   // peripheral model: returns slv_sr MSB first, rotating on falling clock
   logic [7:0] slv_sr = 8'hFF;
   assign spi_miso = slv_sr[7];
   always @(negedge pins_out[0]) slv_sr <= {slv_sr[6:0], slv_sr[7]};

   // line logger: bytes seen on the outgoing data line at rising clock
   logic [7:0] mon_sr = 8'h00;
   int         mon_bits = 0;
   int         rise_cnt = 0;
   int         wr_cnt = 0;
   logic [7:0] wr_log [64];
   logic       cs_high_seen = 1'b0;
   always @(posedge pins_out[0]) begin
      mon_sr = {mon_sr[6:0], pins_out[1]};
      mon_bits++;
      rise_cnt++;
      if (pins_out[3]) cs_high_seen = 1'b1;
      if (mon_bits % 8 == 0) begin
         wr_log[wr_cnt % 64] = mon_sr;
         wr_cnt++;
      end
   end

   // clock high-phase length in system clocks
   int run = 0;
   int hi_len = 0;
   always @(negedge clk) begin
      if (pins_out[0]) run++;
      else if (run != 0) begin
         hi_len = run;
         run = 0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic get(output logic [7:0] b);
      @(negedge clk);
      out_ready = 1'b1;
      while (!out_valid) @(negedge clk);
      b = out_data;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (!in_ready) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic write1(input logic [7:0] b);
      send(8'h11); send(8'h00); send(8'h00); send(b);
      wait_idle();
   endtask

   task automatic read1(output logic [7:0] b);
      fork
         begin send(8'h20); send(8'h00); send(8'h00); end
         get(b);
      join
      wait_idle();
   endtask

   // {byte written, byte returned by peripheral}
   localparam logic [15:0] VEC [6] = '{
      16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h5A_C3, 16'h01_80
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] b;
      logic [7:0] b2;
      int base;
      int r0;
      rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk("R1 pins_out", pins_out, 8'h08);
      chk("R1 pins_oe", pins_oe, 8'h0B);
      chk("R1 err_flag", err_flag, 0);
      chk("R1 out_valid", out_valid, 0);
      chk("R1 in_ready", in_ready, 1);

      // chip select low, slow clock, loopback on
      send(8'h80); send(8'h00); send(8'h0B);
      chk("R2 cs low", pins_out, 8'h00);
      slv_sr = 8'hFF;
      read1(b);
      chk("R7 loopback read", b, 8'h00);
      chk("R3 reset half period", hi_len, 5);
      chk("R11 clock idle", pins_out[0], 0);

      send(8'h85);
      slv_sr = 8'h5A;
      read1(b);
      chk("R7 loopback off read", b, 8'h5A);

      send(8'h8A);
      base = wr_cnt;
      write1(8'hC5);
      chk("R4 bypass half period", hi_len, 1);
      chk("R5 byte on line", wr_log[base % 64], 8'hC5);

      send(8'h86); send(8'h02); send(8'h00);
      write1(8'h3E);
      chk("R3 divisor 2 half period", hi_len, 3);

      send(8'h86); send(8'h00); send(8'h00);
      send(8'h80); send(8'h08); send(8'h0B);

      foreach (VEC[i]) begin
         slv_sr = VEC[i][7:0];
         base = wr_cnt;
         cs_high_seen = 1'b0;
         fork
            begin
               send(8'h80); send(8'h00); send(8'h0B);
               send(8'h11); send(8'h00); send(8'h00); send(VEC[i][15:8]);
               send(8'h20); send(8'h00); send(8'h00);
               send(8'h80); send(8'h08); send(8'h0B);
            end
            get(b);
         join
         wait_idle();
         chk("R5 written byte", wr_log[base % 64], {24'h0, VEC[i][15:8]});
         chk("R6 read byte", b, {24'h0, VEC[i][7:0]});
         chk("R6 data line low in read", wr_log[(base + 1) % 64], 8'h00);
         chk("R8 cs low throughout", cs_high_seen, 0);
         chk("R8 cs released last", pins_out, 8'h08);
      end

      // multi-byte write
      base = wr_cnt;
      send(8'h11); send(8'h02); send(8'h00);
      send(8'h81); send(8'h7E); send(8'h3C);
      wait_idle();
      chk("R5 multi byte 0", wr_log[base % 64], 8'h81);
      chk("R5 multi byte 1", wr_log[(base + 1) % 64], 8'h7E);
      chk("R5 multi byte 2", wr_log[(base + 2) % 64], 8'h3C);

      // back-pressure on the output
      slv_sr = 8'h96;
      r0 = rise_cnt;
      send(8'h20); send(8'h01); send(8'h00);
      repeat (60) @(negedge clk);
      chk("R10 valid held", out_valid, 1);
      chk("R10 clock stalled", rise_cnt - r0, 8);
      chk("R10 input blocked", in_ready, 0);
      chk("R10 data held", out_data, 8'h96);
      get(b);
      get(b2);
      wait_idle();
      chk("R6 first of two", b, 8'h96);
      chk("R6 second of two", b2, 8'h96);

      // bad opcode
      send(8'h55);
      @(negedge clk);
      chk("R9 error raised", err_flag, 1);
      send(8'h80); send(8'hF0); send(8'hF3);
      @(negedge clk);
      chk("R9 next byte parsed", pins_out, 8'hF0);
      chk("R2 direction", pins_oe, 8'hF3);
      chk("R9 error sticky", err_flag, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule